// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block proves that a host processor is still alive by watching the two wires of its serial bus instead of a dedicated kick pin. SCL and SDA are sampled on the fast system clock, passed through a two-flop synchroniser, and fed to a small sequence machine. A complete start-then-stop sequence restarts a timeout counter. The smallest such sequence is a start, one SCL low phase, one SCL high phase and a stop. If the counter reaches the selected interval first, the block raises a one-cycle reset request.

The counter advances on a time-base tick input, so the interval is expressed in ticks. A two-bit period field chooses the interval. Three codes select preset tick counts, by default 1400, 600 and 200 ticks, which at a 1 ms tick give 1.4 s, 600 ms and 200 ms. The fourth code turns the watchdog off. A write strobe loads the field, and every accepted write restarts the count. While the write-protect input is high, writes are ignored.

The sequence machine has four states. SEQ_IDLE waits for a start. SEQ_START means a start was seen and the machine waits for SCL to fall. SEQ_CLKLOW means SCL is low and the machine waits for it to rise. SEQ_CLKHIGH means SCL is high. Its transitions are as follows:
- A start in any state moves to SEQ_START.
- A stop in SEQ_START or SEQ_CLKHIGH returns to SEQ_IDLE. From SEQ_CLKHIGH, that stop also raises the internal kick.
- An SCL fall moves SEQ_START or SEQ_CLKHIGH to SEQ_CLKLOW.
- An SCL rise moves SEQ_CLKLOW to SEQ_CLKHIGH.

Top module: `bus_watchdog`

## Requirements
- R1: After reset, period_sel reads 2'b00 and wd_expire is low.
- R2: Code 2'b00 selects TICKS_LONG ticks, code 2'b01 selects TICKS_MID and code 2'b10 selects TICKS_SHORT. wd_expire is high for exactly one clock, in the cycle after the tick that completes the interval. The count then starts again from zero, so an idle bus gives periodic pulses.
- R3: Code 2'b11 disables the watchdog, and wd_expire never goes high while it is selected.
- R4: When cfg_we is high and wp is low, period_sel takes cfg_wdata on the next clock and the tick count restarts from zero, even if the value does not change.
- R5: When wp is high, cfg_we has no effect: period_sel keeps its value and the tick count is not restarted.
- R6: The tick count restarts when the bus shows this sequence: a start (SDA falls while SCL stays high), then an SCL low phase, then an SCL high phase, then a stop (SDA rises while SCL stays high). A full transaction with many data clocks counts the same way.
- R7: A start followed by a stop with no SCL clocking between them does not restart the count.
- R8: A stop with no preceding start does not restart the count, and neither do SDA changes while SCL is low.
- R9: A repeated start (a second start before a stop) re-arms the sequence. A stop that follows it without a fresh SCL low and high phase does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base tick, one clock wide |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| wp | input | 1 | Write protect; high freezes the period field |
| cfg_we | input | 1 | Period field write strobe |
| cfg_wdata | input | 2 | Period code to write |
| period_sel | output | 2 | Current period code |
| wd_expire | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with TICKS_LONG=40, TICKS_MID=20 and TICKS_SHORT=10. This keeps every interval within a few hundred clocks, so each preset, the periodic re-expiry and the disabled code can all be measured tick by tick. It also leaves room between ticks to replay whole bus sequences on the synchronised lines. These sequences include the minimal kick, a clocked transaction, an unclocked start-stop, a stray stop and a repeated start. The short preset makes the exact tick of expiry visible right after a restart or a locked write.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_START,
        SEQ_CLKLOW,
        SEQ_CLKHIGH
    } seq_state_t;

    localparam logic [1:0] PSEL_LONG  = 2'b00;
    localparam logic [1:0] PSEL_MID   = 2'b01;
    localparam logic [1:0] PSEL_SHORT = 2'b10;
    localparam logic [1:0] PSEL_OFF   = 2'b11;

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/bwd_seq.sv
module bwd_seq
    import bwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic kick
);

    seq_state_t state, state_n;
    logic scl_q, sda_q;
    logic start_det, stop_det, scl_fall, scl_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Start or stop only while SCL stays high across the sample pair
    assign start_det = scl_q & scl & sda_q & ~sda;
    assign stop_det  = scl_q & scl & ~sda_q & sda;
    assign scl_fall  = scl_q & ~scl;
    assign scl_rise  = ~scl_q & scl;

    always_comb begin
        state_n = state;
        unique case (state)
            SEQ_IDLE: begin
                if (start_det) state_n = SEQ_START;
            end
            SEQ_START: begin
                if (start_det)     state_n = SEQ_START;
                else if (stop_det) state_n = SEQ_IDLE;
                else if (scl_fall) state_n = SEQ_CLKLOW;
            end
            SEQ_CLKLOW: begin
                if (scl_rise) state_n = SEQ_CLKHIGH;
            end
            SEQ_CLKHIGH: begin
                if (start_det)     state_n = SEQ_START;
                else if (stop_det) state_n = SEQ_IDLE;
                else if (scl_fall) state_n = SEQ_CLKLOW;
            end
            default: state_n = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        kick = (state == SEQ_CLKHIGH) && stop_det;
    end

endmodule

// File: rtl/bwd_cfg.sv
module bwd_cfg #(
    parameter logic [1:0] RST_SEL = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic [1:0] sel,
    output logic       reload
);

    assign reload = wr_en & ~wp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel <= RST_SEL;
        else if (reload) sel <= wr_data;
    end

endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
    import bwd_pkg::*;
#(
    parameter int TICKS_LONG  = 1400,
    parameter int TICKS_MID   = 600,
    parameter int TICKS_SHORT = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    input  logic       restart,
    output logic       expire
);

    localparam int CNT_W = $clog2(TICKS_LONG + 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(TICKS_LONG - 1);
    localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(TICKS_MID - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(TICKS_SHORT - 1);

    logic [CNT_W-1:0] cnt, last;
    logic             enabled;

    always_comb begin
        unique case (sel)
            PSEL_LONG:  last = LAST_LONG;
            PSEL_MID:   last = LAST_MID;
            PSEL_SHORT: last = LAST_SHORT;
            default:    last = '0;
        endcase
    end

    assign enabled = (sel != PSEL_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (restart || !enabled) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == last) begin
                    cnt    <= '0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
    parameter int TICKS_LONG  = 1400,
    parameter int TICKS_MID   = 600,
    parameter int TICKS_SHORT = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       wp,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic [1:0] period_sel,
    output logic       wd_expire
);

    logic [1:0] bus_sync;
    logic       seq_kick;
    logic       cfg_reload;

    bwd_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    (bus_sync)
    );

    bwd_seq u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .scl  (bus_sync[1]),
        .sda  (bus_sync[0]),
        .kick (seq_kick)
    );

    bwd_cfg #(
        .RST_SEL(2'b00)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wp     (wp),
        .wr_en  (cfg_we),
        .wr_data(cfg_wdata),
        .sel    (period_sel),
        .reload (cfg_reload)
    );

    bwd_timer #(
        .TICKS_LONG (TICKS_LONG),
        .TICKS_MID  (TICKS_MID),
        .TICKS_SHORT(TICKS_SHORT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .sel    (period_sel),
        .restart(seq_kick | cfg_reload),
        .expire (wd_expire)
    );

endmodule

// File: rtl/bwd_chk.sv
module bwd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wp,
    input logic       cfg_we,
    input logic [1:0] cfg_wdata,
    input logic [1:0] period_sel,
    input logic       wd_expire,
    input logic       kick
);

    // R2
    expire_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !wd_expire);

    // R2
    expire_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |-> $past(tick));

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel == 2'b11) |-> !wd_expire);

    // R4
    unlocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wp) |=> (period_sel == $past(cfg_wdata)) && !wd_expire);

    // R5
    locked_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wp) |=> $stable(period_sel));

    // R6
    kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !wd_expire);

endmodule

bind bus_watchdog bwd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wp        (wp),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .period_sel(period_sel),
    .wd_expire (wd_expire),
    .kick      (seq_kick)
);

// File: tb/bus_watchdog_test.sv
module bus_watchdog_test;

    localparam int T_LONG  = 40;
    localparam int T_MID   = 20;
    localparam int T_SHORT = 10;
    localparam int NVEC    = 8;

    // {code, ticks applied after a reloading write, expected pulses}
    localparam int VEC [NVEC][3] = '{
        '{2, 9, 0}, '{2, 10, 1}, '{2, 25, 2}, '{1, 19, 0},
        '{1, 20, 1}, '{0, 39, 0}, '{0, 40, 1}, '{3, 50, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       wp = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic [1:0] period_sel;
    logic       wd_expire;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bus_watchdog #(
        .TICKS_LONG (T_LONG),
        .TICKS_MID  (T_MID),
        .TICKS_SHORT(T_SHORT)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .wp        (wp),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .period_sel(period_sel),
        .wd_expire (wd_expire)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic write_cfg(input logic [1:0] code);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = code;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic run_ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            if (wd_expire) pulses++;
            tick = 1'b0;
        end
    endtask

    task automatic bus(input logic scl, input logic sda);
        @(negedge clk);
        scl_in = scl;
        sda_in = sda;
        repeat (4) @(negedge clk);
    endtask

    task automatic min_kick();
        bus(1, 0);
        bus(0, 0);
        bus(1, 0);
        bus(1, 1);
    endtask

    initial begin
        int p;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 period_sel after reset", period_sel, 0);
        check("R1 wd_expire during reset", wd_expire, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 period_sel after release", period_sel, 0);

        // R2 R3 R4: table walk
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(2'(VEC[v][0]));
            check("R4 field loaded", period_sel, VEC[v][0]);
            run_ticks(VEC[v][1], p);
            check(VEC[v][0] == 3 ? "R3 disabled pulses" : "R2 pulse count", p, VEC[v][2]);
        end

        // R4: rewrite of same code restarts the count
        write_cfg(2'b10);
        run_ticks(6, p);
        write_cfg(2'b10);
        run_ticks(9, p);
        check("R4 restart on rewrite, 9 ticks", p, 0);
        run_ticks(1, p);
        check("R4 restart on rewrite, 10th tick", p, 1);

        // R5: locked write ignored, no restart
        write_cfg(2'b10);
        run_ticks(5, p);
        wp = 1'b1;
        write_cfg(2'b00);
        check("R5 field frozen", period_sel, 2);
        run_ticks(5, p);
        check("R5 count not restarted", p, 1);
        wp = 1'b0;

        // R6: minimal sequence kicks
        write_cfg(2'b10);
        run_ticks(8, p);
        min_kick();
        run_ticks(9, p);
        check("R6 minimal kick delays expiry", p, 0);
        run_ticks(1, p);
        check("R6 expiry after kick", p, 1);

        // R6: full transaction with data bits
        write_cfg(2'b10);
        run_ticks(8, p);
        bus(1, 0);
        bus(0, 0);
        for (int b = 0; b < 9; b++) begin
            bus(0, b[0]);
            bus(1, b[0]);
            bus(0, b[0]);
        end
        bus(0, 0);
        bus(1, 0);
        bus(1, 1);
        run_ticks(9, p);
        check("R6 transaction kick", p, 0);

        // R7: start then stop, no clocking
        write_cfg(2'b10);
        run_ticks(8, p);
        bus(1, 0);
        bus(1, 1);
        run_ticks(2, p);
        check("R7 unclocked start-stop ignored", p, 1);

        // R8: stray stop and SDA toggles with SCL low
        write_cfg(2'b10);
        run_ticks(8, p);
        bus(0, 1);
        bus(0, 0);
        bus(0, 1);
        bus(0, 0);
        bus(1, 0);
        bus(1, 1);
        run_ticks(2, p);
        check("R8 stray stop ignored", p, 1);

        // R9: repeated start then immediate stop
        write_cfg(2'b10);
        run_ticks(8, p);
        bus(1, 0);
        bus(0, 0);
        bus(0, 1);
        bus(1, 1);
        bus(1, 0);
        bus(1, 1);
        run_ticks(2, p);
        check("R9 repeated start needs fresh clock", p, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule